// File: doc/BRIEF.md
# Interrupt Return State Restore Unit

This block produces the machine state register (MSR) and the redirect address for three kinds of return-from-interrupt. An ordinary interrupt return restores state from the save/restore pair. A hypervisor interrupt return restores state from the hypervisor save/restore pair. A vectored system-call return takes its state from the count register and its target from the link register. The caller selects the operation and presents the current MSR, the register that supplies the state (`state_src`) and the register that supplies the address (`addr_src`).

The restore is not a plain copy. The caller sees the result one clock after a valid request. The updated MSR is held on `msr_out`, and the word-aligned target address appears on `redirect_addr` with a single-cycle `redirect_valid` strobe.

All 64-bit buses are declared `[0:63]`, so bit 0 is the most significant bit. The bit numbers below use that convention.

Top module: `irq_return_unit`

## Requirements
- R1: Bits 29..31 and every other bit guarded by the field check stay at their current MSR values when current MSR[29:31] is 3'b010 and state_src[29:31] is 3'b000. Otherwise MSR[29:31] takes state_src[29:31] and the guarded restore below applies.
- R2: redirect_addr is addr_src[0:61] followed by two zero bits, so bits 62 and 63 are always zero.
- R3: For the ordinary return (req_op 2'b00), new MSR[3] is the AND of current MSR[3] and state_src[3]. This is applied whatever the field check gives.
- R4: For the ordinary return, new MSR[51] is state_src[51] when current MSR[3] is 1, and keeps its current value otherwise. This is applied whatever the field check gives.
- R5: For the ordinary and hypervisor returns with the guard open, MSR[48] = src[48]|src[49], MSR[58] = src[58]|src[49] and MSR[59] = src[59]|src[49].
- R6: With the guard open, the ordinary return copies bits 0-2, 4-28, 32, 37-41, 49-50, 52-57 and 60-63 from state_src.
- R7: With the guard open, the hypervisor return (req_op 2'b01) copies bits 0-28, 32, 37-41, 49-57 and 60-63 from state_src.
- R8: With the guard open, the vectored call return (req_op 2'b10) copies the same set as R6, and MSR[48], MSR[58] and MSR[59] all take state_src[49].
- R9: MSR bits not written for the selected operation keep the current MSR value. These always include bits 33-36 and 42-47.
- R10: A request with req_valid=1 and req_op other than 2'b11 updates msr_out and redirect_addr on the next clock edge, and redirect_valid is 1 for that one cycle.
- R11: Cycles without a request leave msr_out and redirect_addr unchanged and redirect_valid at 0. req_op 2'b11 is reserved and counts as no request.
- R12: While rst_n is low, msr_out, redirect_addr and redirect_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Return request strobe |
| req_op | input | 2 | 00 ordinary, 01 hypervisor, 10 vectored call, 11 reserved |
| msr_in | input | 64 | Current MSR |
| state_src | input | 64 | Register supplying the restored state |
| addr_src | input | 64 | Register supplying the return address |
| msr_out | output | 64 | Registered MSR after the return |
| redirect_addr | output | 64 | Registered word-aligned target address |
| redirect_valid | output | 1 | One-cycle strobe marking a new redirect |

## Verification
The assertions assume that `msr_in`, `state_src` and `addr_src` are stable and known during any cycle with `req_valid` high, because they compare registered results against `$past` of those inputs. The bench changes inputs only on falling edges. It drives every combination of the 3-bit guard fields in both MSR and source, both values of the two bit-3 inputs, and every opcode including the reserved one, with random fill in all other bits. Each request is followed by an idle cycle carrying fresh random inputs, so that the single-cycle strobe and the hold behaviour are checked.

// File: rtl/irq_return_unit.sv
module irq_return_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [0:63] msr_in,
  input  logic [0:63] state_src,
  input  logic [0:63] addr_src,
  output logic [0:63] msr_out,
  output logic [0:63] redirect_addr,
  output logic        redirect_valid
);

  localparam logic [1:0] OP_ORD = 2'b00;
  localparam logic [1:0] OP_HYP = 2'b01;
  localparam logic [1:0] OP_VEC = 2'b10;
  localparam logic [1:0] OP_RSV = 2'b11;

  function automatic logic [0:63] copy_mask(input logic hyp);
    logic [0:63] m;
    for (int i = 0; i < 64; i++) begin
      if (hyp)
        m[i] = (i <= 31) || (i == 32) || (i >= 37 && i <= 41) ||
               (i >= 49 && i <= 57) || (i >= 60);
      else
        m[i] = (i <= 2) || (i >= 4 && i <= 32) || (i >= 37 && i <= 41) ||
               (i == 49) || (i == 50) || (i >= 52 && i <= 57) || (i >= 60);
    end
    return m;
  endfunction

  localparam logic [0:63] BASE_MASK = copy_mask(1'b0);
  localparam logic [0:63] HYP_MASK  = copy_mask(1'b1);

  logic        take;
  logic        guard_hold;
  logic [0:63] mask;
  logic [0:63] nxt;

  assign take       = req_valid && (req_op != OP_RSV);
  assign guard_hold = (msr_in[29:31] == 3'b010) && (state_src[29:31] == 3'b000);
  assign mask       = (req_op == OP_HYP) ? HYP_MASK : BASE_MASK;

  always_comb begin
    nxt = msr_in;
    if (req_op == OP_ORD) begin
      nxt[3] = msr_in[3] & state_src[3];
      if (msr_in[3]) nxt[51] = state_src[51];
    end
    if (!guard_hold) begin
      nxt = (nxt & ~mask) | (state_src & mask);
      if (req_op == OP_VEC) begin
        nxt[48] = state_src[49];
        nxt[58] = state_src[49];
        nxt[59] = state_src[49];
      end else begin
        nxt[48] = state_src[48] | state_src[49];
        nxt[58] = state_src[58] | state_src[49];
        nxt[59] = state_src[59] | state_src[49];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msr_out        <= '0;
      redirect_addr  <= '0;
      redirect_valid <= 1'b0;
    end else begin
      redirect_valid <= take;
      if (take) begin
        msr_out       <= nxt;
        redirect_addr <= {addr_src[0:61], 2'b00};
      end
    end
  end

endmodule

module irq_return_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_op,
  input logic [0:63] msr_in,
  input logic [0:63] state_src,
  input logic [0:63] addr_src,
  input logic [0:63] msr_out,
  input logic [0:63] redirect_addr,
  input logic        redirect_valid
);

  a_r1_guard_holds_field: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'b11 && msr_in[29:31] == 3'b010 && state_src[29:31] == 3'b000)
    |=> msr_out[29:31] == $past(msr_in[29:31]));

  a_r2_aligned_target: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> redirect_addr[62:63] == 2'b00);

  a_r3_ordinary_bit3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b00) |=> msr_out[3] == $past(msr_in[3] & state_src[3]));

  a_r9_untouched_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'b11) |=> msr_out[33:36] == $past(msr_in[33:36]) &&
                                       msr_out[42:47] == $past(msr_in[42:47]));

  a_r10_strobe_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'b11) |=> redirect_valid);

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_op != 2'b11) |=> !redirect_valid && $stable(msr_out) && $stable(redirect_addr));

endmodule

bind irq_return_unit irq_return_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .msr_in(msr_in), .state_src(state_src), .addr_src(addr_src),
  .msr_out(msr_out), .redirect_addr(redirect_addr), .redirect_valid(redirect_valid)
);

// File: tb/test_irq_return_unit.sv
module test_irq_return_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [0:63] msr_in = '0;
  logic [0:63] state_src = '0;
  logic [0:63] addr_src = '0;
  logic [0:63] msr_out;
  logic [0:63] redirect_addr;
  logic        redirect_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  irq_return_unit i_irq_return_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .msr_in(msr_in), .state_src(state_src), .addr_src(addr_src),
    .msr_out(msr_out), .redirect_addr(redirect_addr), .redirect_valid(redirect_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [0:63] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic bit copied(input logic [1:0] op, input int i);
    if (op == 2'b01)
      return (i <= 28) || (i >= 29 && i <= 31) || i == 32 || (i >= 37 && i <= 41) ||
             (i >= 49 && i <= 57) || i >= 60;
    return (i <= 2) || (i >= 4 && i <= 28) || (i >= 29 && i <= 31) || i == 32 ||
           (i >= 37 && i <= 41) || i == 49 || i == 50 || (i >= 52 && i <= 57) || i >= 60;
  endfunction

  function automatic logic [0:63] model(input logic [1:0] op, input logic [0:63] m,
                                        input logic [0:63] s);
    logic [0:63] r;
    bit open;
    r = m;
    open = !(m[29:31] == 3'b010 && s[29:31] == 3'b000);
    if (op == 2'b00) begin
      r[3]  = m[3] && s[3];
      r[51] = m[3] ? s[51] : m[51];
    end
    if (open) begin
      for (int i = 0; i < 64; i++)
        if (copied(op, i)) r[i] = s[i];
      if (op == 2'b10) begin
        r[48] = s[49]; r[58] = s[49]; r[59] = s[49];
      end else begin
        r[48] = s[48] | s[49]; r[58] = s[58] | s[49]; r[59] = s[59] | s[49];
      end
    end
    return r;
  endfunction

  task automatic check64(input string req, input logic [0:63] act, input logic [0:63] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic one_return(input logic [1:0] op, input logic [2:0] mf, input logic [2:0] sf,
                            input logic m3, input logic s3);
    logic [0:63] m, s, a, prev_msr, prev_addr, exp_m;
    bit active;
    m = rnd64(); s = rnd64(); a = rnd64();
    m[29:31] = mf; s[29:31] = sf; m[3] = m3; s[3] = s3;
    prev_msr = msr_out; prev_addr = redirect_addr;
    active = (op != 2'b11);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; msr_in = m; state_src = s; addr_src = a;
    @(negedge clk);
    exp_m = active ? model(op, m, s) : prev_msr;
    // R1 R3 R4 R5 R6 R7 R8 R9: full MSR compare against the bench model
    check64(active ? "R1-guard/R3/R4/R5/R6/R7/R8/R9 msr" : "R11 reserved msr", msr_out, exp_m);
    check64(active ? "R2 redirect_addr" : "R11 reserved addr", redirect_addr,
            active ? {a[0:61], 2'b00} : prev_addr);
    check1(active ? "R10 strobe" : "R11 reserved strobe", redirect_valid, active);
    req_valid = 1'b0; req_op = $urandom_range(0, 3);
    msr_in = rnd64(); state_src = rnd64(); addr_src = rnd64();
    @(negedge clk);
    check1("R10 strobe single cycle", redirect_valid, 1'b0);
    check64("R11 idle msr hold", msr_out, exp_m);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    msr_in = rnd64(); state_src = rnd64(); addr_src = rnd64(); req_valid = 1'b1;
    repeat (3) @(negedge clk);
    check64("R12 reset msr", msr_out, '0);
    check64("R12 reset addr", redirect_addr, '0);
    check1("R12 reset strobe", redirect_valid, 1'b0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    for (int op = 0; op < 4; op++)
      for (int mf = 0; mf < 8; mf++)
        for (int sf = 0; sf < 8; sf++)
          for (int b = 0; b < 4; b++)
            one_return(op[1:0], mf[2:0], sf[2:0], b[1], b[0]);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule